// File: doc/BRIEF.md
# Periodic Comparator Event Timer

This block is a memory-mapped event timer. A 64-bit main counter advances once per clock while the global enable is set. Three comparator timers watch it. Each timer raises a status bit when the counter equals its comparator. In periodic mode the timer then moves its comparator forward by a stored period, so it fires at regular intervals. In one-shot mode the comparator stays where it is. Software reaches the global enable, the status word, the main counter and each timer's configuration and comparator over a simple write/read bus. Reads are combinational from the address. A write takes effect at the clock edge where `bus_wr` is high.

A write to a comparator is steered by the timer's mode and by an arm flag. In one-shot mode the write sets the comparator. In periodic mode the write sets only the period. While the arm flag is set, a single write sets both the comparator and the period. This means a periodic timer can be programmed with one write after it has been armed.

The arm flag is a two-state machine in each timer:
- `VS_IDLE`: writes follow the mode rule.
- `VS_ARMED`: the next comparator write loads both registers.

The transitions are:
- `VS_IDLE` → `VS_ARMED`: a configuration write with bit 6 set.
- `VS_ARMED` → `VS_IDLE`: a comparator write, or a configuration write with bit 6 clear.

Top module: `evt_timer_block`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is zero.
- R2: The global configuration register is at 0x010, and its bit 0 is the enable. While enable is 1, the main counter at 0x0F0 increases by exactly one per clock. While enable is 0, it holds its value. A bus write to 0x0F0 loads the counter.
- R3: While enable is 0, every `irq` bit is 0 even if its status is set. Setting enable again restores the `irq` bits that have status and interrupt-enable set.
- R4: In one-shot mode (configuration bit 3 = 0), a comparator write loads the comparator.
- R5: In periodic mode (bit 3 = 1) with the arm flag clear, a comparator write changes only the period. The comparator value read back is unchanged.
- R6: Writing configuration bit 6 = 1 arms the timer. The next comparator write loads both the comparator and the period. The arm flag then clears, and it reads back as configuration bit 6.
- R7: While enabled, a periodic timer whose comparator equals the counter sets its status bit. Its comparator then advances by the period.
- R8: With configuration bit 8 = 1 (32-bit mode), a written comparator keeps only its low 32 bits. Matching then compares only the low 32 bits of the counter.
- R9: Timer n has its configuration at 0x100+0x20·n and its comparator at 0x108+0x20·n, for n = 0..2. The timer index is (address − 0x100) >> 5.
- R10: The status register is at 0x020, with bit n belonging to timer n. Writing 1 to a bit clears it. `irq[n]` equals enable & interrupt-enable (configuration bit 2) & status[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Per-timer interrupt outputs |

## Verification
The assertions assume that each bus write is a single-cycle strobe to one decoded address. They also assume a comparator write never coincides with another write to the same timer. The bench drives writes one at a time, each separated by an idle cycle. It moves the counter or the comparators only while the counter is halted. This way the expected comparator after each run follows arithmetically from the halted count it reads back.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    typedef enum logic {VS_IDLE, VS_ARMED} vs_state_e;

    localparam int CFG_IE_BIT  = 2;
    localparam int CFG_PER_BIT = 3;
    localparam int CFG_VS_BIT  = 6;
    localparam int CFG_M32_BIT = 8;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (wr)  cnt <= wdata;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en && !wr |=> cnt == $past(cnt) + 1'b1);
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !wr |=> $stable(cnt));
endmodule

// File: rtl/evt_comparator_timer.sv
module evt_comparator_timer
    import evt_timer_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         g_en,
    input  logic [W-1:0] cnt,
    input  logic         cfg_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  logic         st_clr,
    output logic [W-1:0] cfg_rd,
    output logic [W-1:0] cmp_rd,
    output logic         status,
    output logic         irq
);
    localparam int HW = W / 2;

    vs_state_e state, state_nx;
    logic ie, per, m32, hit;
    logic [W-1:0] cmp, period, wval;

    always_comb begin
        state_nx = state;
        unique case (state)
            VS_IDLE:  if (cfg_wr && wdata[CFG_VS_BIT]) state_nx = VS_ARMED;
            VS_ARMED: if (cmp_wr || (cfg_wr && !wdata[CFG_VS_BIT])) state_nx = VS_IDLE;
            default:  state_nx = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VS_IDLE;
        else        state <= state_nx;
    end

    assign wval = m32 ? {{HW{1'b0}}, wdata[HW-1:0]} : wdata;
    assign hit  = g_en && (m32 ? (cnt[HW-1:0] == cmp[HW-1:0]) : (cnt == cmp));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie <= 1'b0; per <= 1'b0; m32 <= 1'b0;
            cmp <= '0; period <= '0; status <= 1'b0;
        end else begin
            if (cfg_wr) begin
                ie  <= wdata[CFG_IE_BIT];
                per <= wdata[CFG_PER_BIT];
                m32 <= wdata[CFG_M32_BIT];
            end
            if (cmp_wr) begin
                if (!per || state == VS_ARMED) cmp <= wval;
                if (per || state == VS_ARMED)  period <= wval;
            end else if (hit && per) begin
                if (m32) cmp <= {{HW{1'b0}}, cmp[HW-1:0] + period[HW-1:0]};
                else     cmp <= cmp + period;
            end
            if (hit)         status <= 1'b1;
            else if (st_clr) status <= 1'b0;
        end
    end

    always_comb begin
        cfg_rd = '0;
        cfg_rd[CFG_IE_BIT]  = ie;
        cfg_rd[CFG_PER_BIT] = per;
        cfg_rd[CFG_VS_BIT]  = (state == VS_ARMED);
        cfg_rd[CFG_M32_BIT] = m32;
        cmp_rd = cmp;
        irq    = g_en & ie & status;
    end

    assert_period_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        per && state == VS_IDLE && cmp_wr |=> $stable(cmp));
    assert_setval_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == VS_ARMED && cmp_wr && !cfg_wr |=> state == VS_IDLE);
    assert_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr && m32 && !cfg_wr |=> cmp[W-1:HW] == '0);
    assert_match_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);
endmodule

// File: rtl/evt_timer_block.sv
module evt_timer_block
    import evt_timer_pkg::*;
#(
    parameter int NT = 3,
    parameter int W  = 64,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic [NT-1:0] irq
);
    localparam logic [AW-1:0] A_GCFG   = AW'(12'h010);
    localparam logic [AW-1:0] A_STAT   = AW'(12'h020);
    localparam logic [AW-1:0] A_MAIN   = AW'(12'h0F0);
    localparam logic [AW-1:0] A_TBASE  = AW'(12'h100);
    localparam int            SHIFT    = 5;
    localparam logic [4:0]    OFF_CFG  = 5'h00;
    localparam logic [4:0]    OFF_CMP  = 5'h08;

    logic          g_en;
    logic [W-1:0]  cnt;
    logic [AW-1:0] t_off;
    logic [AW-SHIFT-1:0] t_idx;
    logic          in_tmr;
    logic [NT-1:0] cfg_wr, cmp_wr, status;
    logic [W-1:0]  cfg_rd [NT];
    logic [W-1:0]  cmp_rd [NT];

    assign t_off  = bus_addr - A_TBASE;
    assign t_idx  = t_off[AW-1:SHIFT];
    assign in_tmr = (bus_addr >= A_TBASE) && (int'(t_idx) < NT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           g_en <= 1'b0;
        else if (bus_wr && bus_addr == A_GCFG) g_en <= bus_wdata[0];
    end

    evt_main_counter #(.W(W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .en(g_en),
        .wr(bus_wr && bus_addr == A_MAIN), .wdata(bus_wdata), .cnt(cnt)
    );

    for (genvar n = 0; n < NT; n++) begin : g_tmr
        assign cfg_wr[n] = bus_wr && in_tmr && int'(t_idx) == n && t_off[SHIFT-1:0] == OFF_CFG;
        assign cmp_wr[n] = bus_wr && in_tmr && int'(t_idx) == n && t_off[SHIFT-1:0] == OFF_CMP;
        evt_comparator_timer #(.W(W)) i_tmr (
            .clk(clk), .rst_n(rst_n), .g_en(g_en), .cnt(cnt),
            .cfg_wr(cfg_wr[n]), .cmp_wr(cmp_wr[n]), .wdata(bus_wdata),
            .st_clr(bus_wr && bus_addr == A_STAT && bus_wdata[n]),
            .cfg_rd(cfg_rd[n]), .cmp_rd(cmp_rd[n]),
            .status(status[n]), .irq(irq[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_GCFG)      bus_rdata = {{(W-1){1'b0}}, g_en};
        else if (bus_addr == A_STAT) bus_rdata = W'(status);
        else if (bus_addr == A_MAIN) bus_rdata = cnt;
        else if (in_tmr) begin
            for (int n = 0; n < NT; n++) begin
                if (int'(t_idx) == n) begin
                    if (t_off[SHIFT-1:0] == OFF_CFG) bus_rdata = cfg_rd[n];
                    if (t_off[SHIFT-1:0] == OFF_CMP) bus_rdata = cmp_rd[n];
                end
            end
        end
    end

    assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_GCFG && !bus_wdata[0] |=> irq == '0);
endmodule

// File: tb/test_evt_timer_block.sv
module test_evt_timer_block;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0, bus_rdata;
    logic [2:0]  irq;
    int checks = 0, errors = 0;
    bit done = 0;

    evt_timer_block i_evt_timer_block (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [63:0] adv(logic [63:0] first, logic [63:0] p, logic [63:0] c_lo, logic [63:0] c_hi);
        // matches checked on counter values c_lo .. c_hi-1
        if (c_hi == 0 || c_hi - 1 < first) return first;
        return first + p * ((c_hi - 1 - first) / p + 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, a, b, c, c2, x;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(12'h010, v); chk("R1 gcfg", v, 0);
        rd(12'h020, v); chk("R1 status", v, 0);
        rd(12'h0F0, v); chk("R1 main", v, 0);
        for (int t = 0; t < 3; t++) begin
            rd(12'(12'h100 + 32*t), v); chk("R1 cfg", v, 0);
            rd(12'(12'h108 + 32*t), v); chk("R1 cmp", v, 0);
        end
        chk("R1 irq", irq, 0);

        // R2 halt, write, count
        wr(12'h0F0, 64'h1234);
        repeat (4) @(negedge clk);
        rd(12'h0F0, v); chk("R2 halted load", v, 64'h1234);
        wr(12'h010, 1);
        rd(12'h0F0, a); repeat (7) @(negedge clk); rd(12'h0F0, b);
        chk("R2 step", b - a, 7);
        wr(12'h010, 0);
        rd(12'h0F0, a); repeat (5) @(negedge clk); rd(12'h0F0, b);
        chk("R2 hold", b, a);

        // R9 spacing: distinct one-shot comparators per timer
        for (int t = 0; t < 3; t++) wr(12'(12'h108 + 32*t), 64'h5000 + 64'(t));
        for (int t = 0; t < 3; t++) begin
            rd(12'(12'h108 + 32*t), v); chk("R9 R4 cmp per timer", v, 64'h5000 + 64'(t));
        end

        // R6 R7 R5 periodic sweep over timers and periods
        for (int t = 0; t < 3; t++) begin
            for (int p = 3; p <= 7; p++) begin
                wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h020, 7);
                wr(12'(12'h100 + 32*t), 64'h4C);
                rd(12'(12'h100 + 32*t), v); chk("R6 armed", v[6], 1);
                wr(12'(12'h108 + 32*t), 64'(p));
                rd(12'(12'h100 + 32*t), v); chk("R6 self clear", v[6], 0);
                rd(12'(12'h108 + 32*t), v); chk("R6 cmp loaded", v, 64'(p));
                wr(12'h010, 1);
                repeat (3*p + t) @(negedge clk);
                wr(12'h010, 0);
                rd(12'h0F0, c);
                x = adv(64'(p), 64'(p), 0, c);
                rd(12'(12'h108 + 32*t), v); chk("R7 advance", v, x);
                rd(12'h020, v); chk("R7 status", v[t], 1);
                wr(12'(12'h108 + 32*t), 2);
                rd(12'(12'h108 + 32*t), v); chk("R5 cmp unchanged", v, x);
                wr(12'h010, 1);
                repeat (5) @(negedge clk);
                wr(12'h010, 0);
                rd(12'h0F0, c2);
                rd(12'(12'h108 + 32*t), v); chk("R5 new period", v, adv(x, 2, c, c2));
            end
            wr(12'(12'h100 + 32*t), 0);
        end

        // R4 one-shot keeps comparator, R3 irq gating, R10 W1C
        wr(12'h0F0, 0); wr(12'h020, 7);
        wr(12'h110 + 12'h30, 64'h4);
        wr(12'h148, 12);
        rd(12'h148, v); chk("R4 load", v, 12);
        wr(12'h010, 1);
        repeat (20) @(negedge clk);
        rd(12'h148, v); chk("R4 no advance", v, 12);
        chk("R10 irq on", irq[2], 1);
        wr(12'h010, 0);
        chk("R3 irq off halted", irq[2], 0);
        rd(12'h020, v); chk("R3 status kept", v[2], 1);
        wr(12'h010, 1);
        chk("R3 irq restored", irq[2], 1);
        wr(12'h010, 0);
        wr(12'h020, 64'h2);
        rd(12'h020, v); chk("R10 other bit untouched", v[2], 1);
        wr(12'h020, 64'h4);
        rd(12'h020, v); chk("R10 cleared", v[2], 0);

        // R8 32-bit truncation and low-half match
        wr(12'h100, 64'h104);
        wr(12'h108, 64'hABCD_1234_0000_0005);
        rd(12'h108, v); chk("R8 truncate", v, 5);
        wr(12'h0F0, 64'h1_0000_0000); wr(12'h020, 7);
        wr(12'h010, 1);
        repeat (8) @(negedge clk);
        wr(12'h010, 0);
        rd(12'h020, v); chk("R8 low match", v[0], 1);
        wr(12'h020, 7);
        chk("R10 irq after clear", irq, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule